// File: doc/BRIEF.md
# SMBus Target Transaction Decoder

This block sits on top of a byte-level two-wire target engine and turns that engine's event pulses into whole SMBus transactions. The engine reports a start with write direction, a start with read direction, a stop, a host NACK and each received byte. The decoder collects written bytes in a small buffer. It decides whether a write was a quick command, a send-byte or a command followed by data, and it does so from how many bytes arrived before the stop or the repeated start.

For reads, the decoder passes a request to an attached register file that answers in the same cycle. With the request it gives a flag marking a receive-byte access, or else the latched command code and a running byte offset. The answer comes back as a registered byte one cycle later. Any event sequence that SMBus does not allow sends the decoder into an error state. That state swallows everything until the next stop, which puts the decoder back in idle.

Top module: `smbus_txn_decoder`

## Requirements
- R1: After reset the decoder is idle and `quick_vld`, `send_vld`, `wr_vld` and `rd_valid` are all low.
- R2: A stop after a write start with no bytes pulses `quick_vld` with `quick_rd`=0 for one cycle. A stop directly after a read start from idle pulses `quick_vld` with `quick_rd`=1. In both cases the pulse appears in the cycle after the stop.
- R3: A stop after a write start and exactly one byte pulses `send_vld` in the cycle after the stop, with `send_data` equal to that byte.
- R4: A stop after N≥2 written bytes pulses `wr_vld` in the cycle after the stop. `wr_cmd` is the first byte and `wr_len`=N−1. Data byte i (the i-th byte after the command, counted from 0) sits at `wr_data[8i+7:8i]`.
- R5: The buffer keeps at most BUF_DEPTH (34) bytes. Later bytes of the same write are dropped, so the longest dispatch has `wr_len`=33 and holds the first 33 data bytes.
- R6: A read start after exactly one written byte dispatches nothing and latches that byte as the command. Each later `rd_req` raises `reg_req` in the same cycle, with `reg_recv`=0, `reg_cmd`=command and `reg_offset`=0, 1, 2, … for successive requests. `rd_valid` and `rd_data`=`reg_rdata` follow in the next cycle.
- R7: A read start after N≥2 written bytes first dispatches the write exactly as R4 does. It then enters reading with the first byte as the command and the offset at 0.
- R8: After a read start from idle, the first `rd_req` raises `reg_req` with `reg_recv`=1 and returns `reg_rdata` in the next cycle. A following stop dispatches nothing.
- R9: A host NACK during reading ends the reading phase, so a later `rd_req` returns 0x00 without `reg_req`. A NACK in idle or during writing enters the error state.
- R10: The decoder enters the error state on any of these: a write start outside idle, a read start with no buffered byte, a read start outside idle or writing, or a read request outside receive-byte or reading. In the error state `rd_req` returns 0x00 without `reg_req`, and a stop dispatches nothing and returns the decoder to idle.
- R11: A byte received in the same cycle as the stop or read start that ends a write is counted in that write. Bytes received outside the writing phase are discarded.
- R12: When several control pulses arrive in one cycle, they are ranked stop, then NACK, then read start, then write start. Only the highest-ranked pulse acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start_wr | input | 1 | Start or repeated start, write direction |
| ev_start_rd | input | 1 | Start or repeated start, read direction |
| ev_stop | input | 1 | Stop condition |
| ev_nack | input | 1 | Host NACKed the last read byte |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Engine needs the next byte to transmit |
| reg_rdata | input | 8 | Same-cycle answer of the register file |
| quick_vld | output | 1 | Quick command dispatched |
| quick_rd | output | 1 | Direction bit of the quick command (1 = read) |
| send_vld | output | 1 | Send-byte dispatched |
| send_data | output | 8 | Byte of the send-byte |
| wr_vld | output | 1 | Command-plus-data write dispatched |
| wr_cmd | output | 8 | Command code of the write |
| wr_len | output | 6 | Number of data bytes after the command |
| wr_data | output | 264 | Data bytes, byte i at bits 8i+7:8i |
| reg_req | output | 1 | Read request to the register file |
| reg_recv | output | 1 | Request is a receive-byte access |
| reg_cmd | output | 8 | Latched command code for reading |
| reg_offset | output | 8 | Byte offset within the read |
| rd_valid | output | 1 | Returned byte valid |
| rd_data | output | 8 | Returned byte |

## Verification
A write can receive its last byte in the very cycle it is closed, because the received-byte strobe and the stop (or the repeated read start) can both be high on the same edge. The bench sets up this overlap both in directed cases and in random write transactions that end this way by chance. It judges the overlap by requiring that the dispatch class, `wr_len` and the data bytes include the coinciding byte. A second overlap is a stop together with a write start. The bench provokes it and then confirms that only the stop acted, by checking that a later read start and stop give a quick read.

// File: rtl/smbus_txn_pkg.sv
package smbus_txn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_RECV  = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4,
    ST_ERR   = 3'd5
  } txn_state_e;
endpackage

// File: rtl/smbus_wr_buffer.sv
module smbus_wr_buffer #(
  parameter int DEPTH = 34,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DW-1:0]       din,
  input  logic                clr,
  output logic [CW-1:0]       cnt_eff_o,
  output logic [DW-1:0]       byte0_eff_o,
  output logic [DEPTH*DW-1:0] mem_flat_o
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, store;

  assign full  = (cnt_q == FULL_CNT);
  assign store = wr_en && !full;

  always_comb begin
    cnt_d = cnt_q + CW'(store);
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (store) mem_q[cnt_q[IW-1:0]] <= din;
      cnt_q <= cnt_d;
    end
  end

  // count including a byte landing in the closing cycle
  assign cnt_eff_o   = cnt_q + CW'(store);
  assign byte0_eff_o = (cnt_q == '0) ? din : mem_q[0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign mem_flat_o[g*DW +: DW] = mem_q[g];
  end

  // R5: the byte count never passes the buffer depth
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R5: a full buffer ignores further bytes
  a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !clr |=> cnt_q == FULL_CNT && $stable(mem_q[DEPTH-1]));
endmodule

// File: rtl/smbus_txn_fsm.sv
module smbus_txn_fsm
  import smbus_txn_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start_wr,
  input  logic          ev_start_rd,
  input  logic          ev_stop,
  input  logic          ev_nack,
  input  logic          rx_valid,
  input  logic          rd_req,
  input  logic [CW-1:0] cnt_eff,
  input  logic [DW-1:0] byte0_eff,
  input  logic [DW-1:0] reg_rdata,
  output logic          buf_wr_en,
  output logic          buf_clr,
  output logic          quick_vld,
  output logic          quick_rd,
  output logic          send_vld,
  output logic          wr_vld,
  output logic [CW-1:0] wr_len,
  output logic          reg_req,
  output logic          reg_recv,
  output logic [DW-1:0] reg_cmd,
  output logic [OW-1:0] reg_offset,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  txn_state_e    state_q, state_d;
  logic [DW-1:0] cmd_q, cmd_d;
  logic [OW-1:0] off_q, off_d;
  logic          qv_d, qr_d, sv_d, wv_d;
  logic [CW-1:0] len_d;
  logic          rd_ok, any_ctrl;

  assign rd_ok     = (state_q == ST_RECV) || (state_q == ST_READ);
  assign any_ctrl  = ev_stop || ev_nack || ev_start_rd || ev_start_wr;
  assign buf_wr_en = (state_q == ST_WRITE) && rx_valid;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    off_d   = off_q;
    qv_d    = 1'b0;
    qr_d    = quick_rd;
    sv_d    = 1'b0;
    wv_d    = 1'b0;
    len_d   = wr_len;
    buf_clr = 1'b0;
    if (ev_stop) begin
      state_d = ST_IDLE;
      buf_clr = 1'b1;
      off_d   = '0;
      if (state_q == ST_WRITE) begin
        if (cnt_eff == '0) begin
          qv_d = 1'b1;
          qr_d = 1'b0;
        end else if (cnt_eff == CW'(1)) begin
          sv_d = 1'b1;
        end else begin
          wv_d  = 1'b1;
          len_d = cnt_eff - CW'(1);
        end
      end else if (state_q == ST_RECV) begin
        qv_d = 1'b1;
        qr_d = 1'b1;
      end
    end else if (ev_nack) begin
      if (state_q == ST_READ || state_q == ST_DONE) state_d = ST_DONE;
      else                                          state_d = ST_ERR;
    end else if (ev_start_rd) begin
      if (state_q == ST_IDLE) begin
        state_d = ST_RECV;
      end else if (state_q == ST_WRITE && cnt_eff != '0) begin
        state_d = ST_READ;
        cmd_d   = byte0_eff;
        off_d   = '0;
        buf_clr = 1'b1;
        if (cnt_eff != CW'(1)) begin
          wv_d  = 1'b1;
          len_d = cnt_eff - CW'(1);
        end
      end else begin
        state_d = ST_ERR;
      end
    end else if (ev_start_wr) begin
      state_d = (state_q == ST_IDLE) ? ST_WRITE : ST_ERR;
    end else if (rd_req) begin
      case (state_q)
        ST_RECV: state_d = ST_DONE;
        ST_READ: off_d   = off_q + OW'(1);
        default: state_d = ST_ERR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_q     <= '0;
      off_q     <= '0;
      quick_vld <= 1'b0;
      quick_rd  <= 1'b0;
      send_vld  <= 1'b0;
      wr_vld    <= 1'b0;
      wr_len    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd_d;
      off_q     <= off_d;
      quick_vld <= qv_d;
      quick_rd  <= qr_d;
      send_vld  <= sv_d;
      wr_vld    <= wv_d;
      wr_len    <= len_d;
      rd_valid  <= rd_req;
      if (rd_req) rd_data <= rd_ok ? reg_rdata : '0;
    end
  end

  assign reg_req    = rd_req && rd_ok;
  assign reg_recv   = (state_q == ST_RECV);
  assign reg_cmd    = cmd_q;
  assign reg_offset = off_q;

  // R10: the error state is left only through a stop
  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ERR && !ev_stop |=> state_q == ST_ERR);
  // R12: a stop always wins and lands in idle
  a_r12_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> state_q == ST_IDLE);
  // R2: at most one kind of dispatch per cycle
  a_r2_one_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({quick_vld, send_vld, wr_vld}));
  // R6: the offset advances by one per read in the reading phase
  a_r6_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_READ && rd_req && !any_ctrl |=> reg_offset == $past(reg_offset) + OW'(1));
  // R10: a refused read returns zero
  a_r10_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ok |=> rd_valid && rd_data == '0);
  // R4: a command write always carries at least one data byte
  a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> wr_len != '0);
endmodule

// File: rtl/smbus_txn_decoder.sv
module smbus_txn_decoder #(
  parameter int BUF_DEPTH = 34,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 8,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_start_wr,
  input  logic                          ev_start_rd,
  input  logic                          ev_stop,
  input  logic                          ev_nack,
  input  logic                          rx_valid,
  input  logic [DATA_W-1:0]             rx_data,
  input  logic                          rd_req,
  input  logic [DATA_W-1:0]             reg_rdata,
  output logic                          quick_vld,
  output logic                          quick_rd,
  output logic                          send_vld,
  output logic [DATA_W-1:0]             send_data,
  output logic                          wr_vld,
  output logic [DATA_W-1:0]             wr_cmd,
  output logic [CNT_W-1:0]              wr_len,
  output logic [(BUF_DEPTH-1)*DATA_W-1:0] wr_data,
  output logic                          reg_req,
  output logic                          reg_recv,
  output logic [DATA_W-1:0]             reg_cmd,
  output logic [OFF_W-1:0]              reg_offset,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data
);
  logic                        buf_wr_en, buf_clr;
  logic [CNT_W-1:0]            cnt_eff;
  logic [DATA_W-1:0]           byte0_eff;
  logic [BUF_DEPTH*DATA_W-1:0] mem_flat;

  smbus_wr_buffer #(.DEPTH(BUF_DEPTH), .DW(DATA_W), .CW(CNT_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_wr_en), .din(rx_data), .clr(buf_clr),
    .cnt_eff_o(cnt_eff), .byte0_eff_o(byte0_eff), .mem_flat_o(mem_flat)
  );

  smbus_txn_fsm #(.DW(DATA_W), .CW(CNT_W), .OW(OFF_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd),
    .ev_stop(ev_stop), .ev_nack(ev_nack), .rx_valid(rx_valid), .rd_req(rd_req),
    .cnt_eff(cnt_eff), .byte0_eff(byte0_eff), .reg_rdata(reg_rdata),
    .buf_wr_en(buf_wr_en), .buf_clr(buf_clr), .quick_vld(quick_vld),
    .quick_rd(quick_rd), .send_vld(send_vld), .wr_vld(wr_vld), .wr_len(wr_len),
    .reg_req(reg_req), .reg_recv(reg_recv), .reg_cmd(reg_cmd),
    .reg_offset(reg_offset), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign send_data = mem_flat[DATA_W-1:0];
  assign wr_cmd    = mem_flat[DATA_W-1:0];
  assign wr_data   = mem_flat[BUF_DEPTH*DATA_W-1:DATA_W];
endmodule

// File: tb/test_smbus_txn_decoder.sv
module test_smbus_txn_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 34;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0;
  logic rx_valid = 0, rd_req = 0;
  logic [7:0] rx_data = '0;
  logic [7:0] reg_rdata;
  logic quick_vld, quick_rd, send_vld, wr_vld, reg_req, reg_recv, rd_valid;
  logic [7:0] send_data, wr_cmd, reg_cmd, reg_offset, rd_data;
  logic [5:0] wr_len;
  logic [(DEPTH-1)*8-1:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_rd(input logic recv, input logic [7:0] cmd, input logic [7:0] off);
    return recv ? 8'hA5 : (cmd ^ (off * 8'd7 + 8'd3));
  endfunction
  assign reg_rdata = model_rd(reg_recv, reg_cmd, reg_offset);

  smbus_txn_decoder i_smbus_txn_decoder (
    .clk(clk), .rst_n(rst_n), .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd),
    .ev_stop(ev_stop), .ev_nack(ev_nack), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_req(rd_req), .reg_rdata(reg_rdata), .quick_vld(quick_vld), .quick_rd(quick_rd),
    .send_vld(send_vld), .send_data(send_data), .wr_vld(wr_vld), .wr_cmd(wr_cmd),
    .wr_len(wr_len), .wr_data(wr_data), .reg_req(reg_req), .reg_recv(reg_recv),
    .reg_cmd(reg_cmd), .reg_offset(reg_offset), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  int n_q = 0, n_s = 0, n_w = 0;
  logic cap_qrd;
  logic [7:0] cap_sdata, cap_cmd;
  logic [5:0] cap_len;
  logic [(DEPTH-1)*8-1:0] cap_data;
  logic [7:0] bq [40];
  int q0, s0, w0;

  always @(negedge clk) if (rst_n) begin
    if (quick_vld) begin n_q++; cap_qrd = quick_rd; end
    if (send_vld)  begin n_s++; cap_sdata = send_data; end
    if (wr_vld)    begin n_w++; cap_cmd = wr_cmd; cap_len = wr_len; cap_data = wr_data; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    q0 = n_q; s0 = n_s; w0 = n_w;
  endtask

  task automatic pulse_wr(); ev_start_wr = 1; @(negedge clk); ev_start_wr = 0; endtask
  task automatic pulse_rd(); ev_start_rd = 1; @(negedge clk); ev_start_rd = 0; endtask
  task automatic pulse_stop(); ev_stop = 1; @(negedge clk); ev_stop = 0; @(negedge clk); endtask
  task automatic pulse_nack(); ev_nack = 1; @(negedge clk); ev_nack = 0; endtask
  task automatic rx(input logic [7:0] b);
    rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
  endtask

  // kind: 0 none, 1 quick, 2 send, 3 command write
  task automatic exp_disp(input string tag, input int kind, input logic qrd, input int nbytes);
    int st;
    chk({tag, " quick count"}, n_q - q0, (kind == 1) ? 1 : 0);
    chk({tag, " send count"},  n_s - s0, (kind == 2) ? 1 : 0);
    chk({tag, " write count"}, n_w - w0, (kind == 3) ? 1 : 0);
    if (kind == 1) chk({tag, " quick dir"}, cap_qrd, qrd);
    if (kind == 2) chk({tag, " send byte"}, cap_sdata, bq[0]);
    if (kind == 3) begin
      st = (nbytes > DEPTH) ? DEPTH : nbytes;
      chk({tag, " cmd"}, cap_cmd, bq[0]);
      chk({tag, " len"}, cap_len, st - 1);
      for (int i = 0; i < st - 1; i++) chk({tag, " data"}, cap_data[i*8 +: 8], bq[i+1]);
    end
  endtask

  task automatic do_write(input string tag, input int n, input bit merge);
    snap();
    pulse_wr();
    for (int i = 0; i < n; i++) begin
      if (merge && i == n - 1) begin
        rx_valid = 1; rx_data = bq[i]; ev_stop = 1;
        @(negedge clk); rx_valid = 0; ev_stop = 0; @(negedge clk);
      end else rx(bq[i]);
    end
    if (!(merge && n > 0)) pulse_stop();
    @(negedge clk);
    exp_disp(tag, (n == 0) ? 1 : (n == 1) ? 2 : 3, 1'b0, n);
  endtask

  task automatic read_ok(input string tag, input logic recv, input logic [7:0] cmd, input logic [7:0] off);
    rd_req = 1; #1;
    chk({tag, " reg_req"}, reg_req, 1'b1);
    chk({tag, " reg_recv"}, reg_recv, recv);
    if (!recv) begin
      chk({tag, " reg_cmd"}, reg_cmd, cmd);
      chk({tag, " reg_offset"}, reg_offset, off);
    end
    @(negedge clk); rd_req = 0;
    chk({tag, " rd_valid"}, rd_valid, 1'b1);
    chk({tag, " rd_data"}, rd_data, model_rd(recv, cmd, off));
  endtask

  task automatic read_bad(input string tag);
    rd_req = 1; #1;
    chk({tag, " no reg_req"}, reg_req, 1'b0);
    @(negedge clk); rd_req = 0;
    chk({tag, " rd_valid"}, rd_valid, 1'b1);
    chk({tag, " zero data"}, rd_data, 8'h00);
  endtask

  task automatic do_read(input string tag, input int k, input int m, input bit merge);
    snap();
    pulse_wr();
    for (int i = 0; i < k - 1; i++) rx(bq[i]);
    if (merge) begin
      rx_valid = 1; rx_data = bq[k-1]; ev_start_rd = 1;
      @(negedge clk); rx_valid = 0; ev_start_rd = 0;
    end else begin
      rx(bq[k-1]); pulse_rd();
    end
    for (int j = 0; j < m; j++) read_ok(tag, 1'b0, bq[0], 8'(j));
    pulse_nack();
    read_bad({tag, " R9 after nack"});
    pulse_stop();
    @(negedge clk);
    exp_disp(tag, (k > 1) ? 3 : 0, 1'b0, k);
  endtask

  initial begin
    int seed, n, k;
    bit merge;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk("R1 quick_vld", quick_vld, 0);
    chk("R1 send_vld", send_vld, 0);
    chk("R1 wr_vld", wr_vld, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 quick write and quick read
    do_write("R2 quick write", 0, 0);
    snap(); pulse_rd(); pulse_stop(); @(negedge clk);
    exp_disp("R2 quick read", 1, 1'b1, 0);

    // R3 send byte
    bq[0] = 8'h3C; do_write("R3 send", 1, 0);
    // R4 command write
    for (int i = 0; i < 5; i++) bq[i] = 8'(8'h10 + i * 3);
    do_write("R4 write", 5, 0);
    // R5 overflow
    for (int i = 0; i < 36; i++) bq[i] = 8'(i * 5 + 1);
    do_write("R5 full", 36, 0);
    do_write("R5 exact", 34, 1);
    // R11 merged last byte
    bq[0] = 8'h77; do_write("R11 merged send", 1, 1);
    bq[0] = 8'h21; bq[1] = 8'h42; do_write("R11 merged write", 2, 1);
    // R11 byte outside writing discarded
    snap(); rx(8'h99); pulse_wr(); pulse_stop(); @(negedge clk);
    exp_disp("R11 discard idle byte", 1, 1'b0, 0);

    // R6 read with one-byte command, R7 with dispatch
    bq[0] = 8'h5A; do_read("R6 read", 1, 4, 0);
    bq[0] = 8'hC3; bq[1] = 8'h11; bq[2] = 8'h22; do_read("R7 read", 3, 2, 0);
    bq[0] = 8'h0F; bq[1] = 8'hF0; do_read("R7 R11 merged read", 2, 1, 1);

    // R8 receive byte
    snap(); pulse_rd(); read_ok("R8 recv", 1'b1, 8'h00, 8'h00);
    read_bad("R8 second read"); pulse_stop(); @(negedge clk);
    exp_disp("R8 stop after recv", 0, 1'b0, 0);

    // R9 nack in writing
    snap(); pulse_wr(); pulse_nack(); pulse_stop(); @(negedge clk);
    exp_disp("R9 nack in write", 0, 1'b0, 0);

    // R10 errors
    snap(); pulse_wr(); pulse_wr(); read_bad("R10 double start"); pulse_stop(); @(negedge clk);
    exp_disp("R10 double start", 0, 1'b0, 0);
    snap(); pulse_wr(); pulse_rd(); read_bad("R10 empty read start"); pulse_stop(); @(negedge clk);
    exp_disp("R10 empty read start", 0, 1'b0, 0);
    read_bad("R10 read in idle"); pulse_stop();
    bq[0] = 8'h66; do_write("R10 recovery", 1, 0);

    // R12 stop and write start together
    snap(); pulse_wr(); bq[0] = 8'hAB; bq[1] = 8'hCD; rx(bq[0]); rx(bq[1]);
    ev_stop = 1; ev_start_wr = 1; @(negedge clk); ev_stop = 0; ev_start_wr = 0;
    @(negedge clk); @(negedge clk);
    exp_disp("R12 stop wins", 3, 1'b0, 2);
    snap(); pulse_rd(); pulse_stop(); @(negedge clk);
    exp_disp("R12 idle after", 1, 1'b1, 0);

    // random mix
    for (int t = 0; t < 60; t++) begin
      if ($urandom_range(0, 2) != 0) begin
        n = $urandom_range(0, 37);
        merge = $urandom_range(0, 1);
        for (int i = 0; i < 40; i++) bq[i] = 8'($urandom);
        do_write("R4 random write", n, merge);
      end else begin
        k = $urandom_range(1, 5);
        merge = $urandom_range(0, 1);
        for (int i = 0; i < 40; i++) bq[i] = 8'($urandom);
        do_read("R6 random read", k, $urandom_range(1, 5), merge);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule